// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the bit timing for one serial channel running from a fixed system clock. Each bit period lasts an integer number of clocks, the programmed divisor. A 16-bit stretch mask then lengthens chosen bit positions of the frame by a single clock. Over a whole character, this spreads the fractional remainder of the ideal period without an accumulator and without an oversampling clock.

Transmit and receive timing run as two independent lanes, each with its own mask. The transmit lane emits a one-clock strobe at the end of every bit period, which is when the shifter moves to the next bit. The receive lane emits a one-clock strobe near the middle of every bit period, which is when the line is sampled. Each lane is restarted by a start strobe: on the transmit side when a character is launched, and on the receive side when the receiver sees a start-bit falling edge while idle. All counting therefore restarts at every character, and timing error cannot carry over from one character to the next. The divisor and both masks are values a register interface supplies. This block does not compute them.

Top module: `fractional_brg`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_tick`, `rx_sample`, `tx_busy` and `rx_busy` are low, and `tx_bit_idx` and `rx_bit_idx` are 0.
- R2: Bit position n of a frame (n = 0 is the start bit) lasts D clocks when bit n of that lane's mask is 0, and D+1 clocks when it is 1. D is the effective divisor.
- R3: `tx_tick` is a one-clock pulse. It is high in the cycle after the clock edge that ends each transmit bit period, and the first period begins at the edge that samples `tx_start`. `tx_bit_idx` moves to the next position at that same edge and reads 0 after the last tick.
- R4: A frame of F bit positions lasts F·D plus the number of ones in mask bits F-1..0. Mask bits at positions F and above have no effect.
- R5: `rx_sample` is high in the cycle after the bit counter reaches floor(P/2), where P is the current receive bit period. `rx_bit_idx` holds the index of the bit being sampled.
- R6: The transmit lane uses only `tx_mask` and the receive lane uses only `rx_mask`.
- R7: A start strobe restarts its lane even in the middle of a frame. In the next cycle that lane is busy at bit position 0, and all later timing is counted from the new start.
- R8: A divisor below 4 acts as 4, so neither strobe is ever high in two consecutive cycles.
- R9: A lane's busy flag falls at the edge that ends its last bit period. After that the lane emits no strobe until its next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 19 | Integer clocks per bit period |
| tx_mask | input | 16 | Transmit stretch mask, bit n adds one clock to bit position n |
| rx_mask | input | 16 | Receive stretch mask, bit n adds one clock to bit position n |
| frame_bits | input | 4 | Bit positions per frame, start and stop bits included |
| tx_start | input | 1 | Start or restart the transmit lane |
| rx_start | input | 1 | Start or restart the receive lane (start edge detected) |
| tx_tick | output | 1 | Transmit bit-boundary strobe |
| tx_bit_idx | output | 4 | Current transmit bit position |
| tx_busy | output | 1 | Transmit frame in progress |
| rx_sample | output | 1 | Receive mid-bit sample strobe |
| rx_bit_idx | output | 4 | Current receive bit position |
| rx_busy | output | 1 | Receive frame in progress |

## Verification
The checker tests the cycle-level rules on every clock. Strobes occur only inside a busy frame and never in two consecutive cycles. A bit position changes only at a bit boundary or a restart. A start always leaves its lane busy at position 0. Exact timing can only be shown by the bench scenarios, because each one knows the divisor, mask and frame length it programmed. That timing covers the clock count of every boundary and sample point, the frame total against the mask popcount, whether upper mask bits are ignored, divisor clamping, and mid-frame restart.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int DIV_W   = 19;
  localparam int MASK_W  = 16;
  localparam int IDX_W   = $clog2(MASK_W);
  localparam int MIN_DIV = 4;
endpackage

// File: rtl/fbg_period.sv
module fbg_period #(
  parameter int DIV_W   = fbg_pkg::DIV_W,
  parameter int MASK_W  = fbg_pkg::MASK_W,
  parameter int MIN_DIV = fbg_pkg::MIN_DIV,
  localparam int IDX_W  = $clog2(MASK_W),
  localparam int CNT_W  = DIV_W + 1
) (
  input  logic [DIV_W-1:0]  divisor,
  input  logic [MASK_W-1:0] mask,
  input  logic [IDX_W-1:0]  idx,
  output logic [CNT_W-1:0]  period
);
  logic [DIV_W-1:0] eff_div;

  // clamp to the shortest period the lanes can time
  always_comb begin
    eff_div = (divisor < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : divisor;
    period  = {1'b0, eff_div} + CNT_W'(mask[idx]);
  end
endmodule

// File: rtl/fbg_lane.sv
module fbg_lane #(
  parameter int DIV_W   = fbg_pkg::DIV_W,
  parameter int MASK_W  = fbg_pkg::MASK_W,
  parameter bit MID_BIT = 1'b0,
  localparam int IDX_W  = $clog2(MASK_W),
  localparam int CNT_W  = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [MASK_W-1:0] mask,
  input  logic [IDX_W-1:0]  frame_bits,
  output logic              strobe,
  output logic [IDX_W-1:0]  idx,
  output logic              busy
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] target;
  logic             at_end;
  logic             last_bit;

  fbg_period #(.DIV_W(DIV_W), .MASK_W(MASK_W)) u_period (
    .divisor (divisor),
    .mask    (mask),
    .idx     (idx),
    .period  (period)
  );

  generate
    if (MID_BIT) begin : g_mid
      assign target = period >> 1;
    end else begin : g_end
      assign target = period - CNT_W'(1);
    end
  endgenerate

  assign at_end   = (cnt == period - CNT_W'(1));
  assign last_bit = (idx == IDX_W'(frame_bits - IDX_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (start) begin
        cnt  <= '0;
        idx  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        strobe <= (cnt == target);
        if (at_end) begin
          cnt <= '0;
          if (last_bit) begin
            busy <= 1'b0;
            idx  <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fractional_brg.sv
module fractional_brg #(
  parameter int DIV_W  = fbg_pkg::DIV_W,
  parameter int MASK_W = fbg_pkg::MASK_W,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [MASK_W-1:0] tx_mask,
  input  logic [MASK_W-1:0] rx_mask,
  input  logic [IDX_W-1:0]  frame_bits,
  input  logic              tx_start,
  input  logic              rx_start,
  output logic              tx_tick,
  output logic [IDX_W-1:0]  tx_bit_idx,
  output logic              tx_busy,
  output logic              rx_sample,
  output logic [IDX_W-1:0]  rx_bit_idx,
  output logic              rx_busy
);
  fbg_lane #(.DIV_W(DIV_W), .MASK_W(MASK_W), .MID_BIT(1'b0)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .start      (tx_start),
    .divisor    (divisor),
    .mask       (tx_mask),
    .frame_bits (frame_bits),
    .strobe     (tx_tick),
    .idx        (tx_bit_idx),
    .busy       (tx_busy)
  );

  fbg_lane #(.DIV_W(DIV_W), .MASK_W(MASK_W), .MID_BIT(1'b1)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .start      (rx_start),
    .divisor    (divisor),
    .mask       (rx_mask),
    .frame_bits (frame_bits),
    .strobe     (rx_sample),
    .idx        (rx_bit_idx),
    .busy       (rx_busy)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int IDX_W = fbg_pkg::IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_start,
  input logic             rx_start,
  input logic             tx_tick,
  input logic [IDX_W-1:0] tx_bit_idx,
  input logic             tx_busy,
  input logic             rx_sample,
  input logic [IDX_W-1:0] rx_bit_idx,
  input logic             rx_busy
);
  AST_TX_TICK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    tx_tick |-> $past(tx_busy)); // R9
  AST_RX_SAMPLE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    rx_sample |-> rx_busy); // R9
  AST_TX_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    tx_tick |=> !tx_tick); // R8
  AST_RX_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    rx_sample |=> !rx_sample); // R8
  AST_TX_IDX_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (tx_bit_idx != $past(tx_bit_idx)) |-> (tx_tick || $past(tx_start))); // R3
  AST_TX_RESTART: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> (tx_busy && tx_bit_idx == '0)); // R7
  AST_RX_RESTART: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> (rx_busy && rx_bit_idx == '0)); // R7
endmodule

bind fractional_brg fbg_checker u_chk (.*);

// File: tb/fractional_brg_test.sv
module fractional_brg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] divisor = 19'd4;
  logic [15:0] tx_mask = '0;
  logic [15:0] rx_mask = '0;
  logic [3:0]  frame_bits = 4'd10;
  logic        tx_start = 1'b0;
  logic        rx_start = 1'b0;
  logic        tx_tick, tx_busy, rx_sample, rx_busy;
  logic [3:0]  tx_bit_idx, rx_bit_idx;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  fractional_brg uut (
    .clk(clk), .rst(rst), .divisor(divisor), .tx_mask(tx_mask),
    .rx_mask(rx_mask), .frame_bits(frame_bits), .tx_start(tx_start),
    .rx_start(rx_start), .tx_tick(tx_tick), .tx_bit_idx(tx_bit_idx),
    .tx_busy(tx_busy), .rx_sample(rx_sample), .rx_bit_idx(rx_bit_idx),
    .rx_busy(rx_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Start one lane, then compare each strobe time, the index and the end of the frame.
  task automatic run_frame(input bit is_rx, input int div, input logic [15:0] tm,
                           input logic [15:0] rm, input int nbits, input int pre, input string req);
    int exp_t[16];
    int exp_i[16];
    int acc = 0;
    int ev = 0;
    int eff = (div < 4) ? 4 : div;
    logic [15:0] m = is_rx ? rm : tm;
    @(negedge clk);
    divisor = 19'(div); tx_mask = tm; rx_mask = rm; frame_bits = 4'(nbits);
    if (pre > 0) begin
      if (is_rx) rx_start = 1'b1; else tx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0; tx_start = 1'b0;
      repeat (pre) @(negedge clk);
    end
    for (int b = 0; b < nbits; b++) begin
      int p = eff + int'(m[b]);
      if (is_rx) begin
        exp_t[b] = acc + p / 2 + 1;
        exp_i[b] = b;
      end else begin
        exp_t[b] = acc + p;
        exp_i[b] = (b + 1 == nbits) ? 0 : b + 1;
      end
      acc += p;
    end
    if (is_rx) rx_start = 1'b1; else tx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0; tx_start = 1'b0;
    check((is_rx ? rx_busy : tx_busy) && (is_rx ? rx_bit_idx : tx_bit_idx) == 0,
          {req, " R7 busy at index 0 after start"}, int'(is_rx ? rx_bit_idx : tx_bit_idx), 0);
    for (int k = 1; k <= acc + 4; k++) begin
      @(negedge clk);
      if (is_rx ? rx_sample : tx_tick) begin
        if (ev < nbits) begin
          check(k == exp_t[ev], {req, " strobe time"}, k, exp_t[ev]);
          check(int'(is_rx ? rx_bit_idx : tx_bit_idx) == exp_i[ev], {req, " bit index"},
                int'(is_rx ? rx_bit_idx : tx_bit_idx), exp_i[ev]);
        end else begin
          check(1'b0, {req, " R9 strobe after frame"}, k, 0);
        end
        ev++;
      end
      if (k == acc - 1)
        check(is_rx ? rx_busy : tx_busy, {req, " R9 busy before end"}, 0, 1);
      if (k == acc)
        check(!(is_rx ? rx_busy : tx_busy), {req, " R4 R9 busy falls at frame end"}, 1, 0);
    end
    check(ev == nbits, {req, " strobe count"}, ev, nbits);
  endtask

  task automatic test_reset();
    check(!tx_tick && !rx_sample && !tx_busy && !rx_busy, "R1 strobes and busy low", 1, 0);
    check(tx_bit_idx == 0 && rx_bit_idx == 0, "R1 indices zero", int'(tx_bit_idx), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_frame(1'b0, 4,   16'h0000, 16'h0000, 10, 0, "R2 R3 tx min divisor no mask");
    run_frame(1'b0, 7,   16'h0155, 16'h0000, 11, 0, "R2 R3 R4 tx mask 0x155");
    run_frame(1'b0, 5,   16'hFFFF, 16'h0000, 10, 0, "R4 tx upper mask bits ignored");
    run_frame(1'b1, 9,   16'h0FFF, 16'h0000, 10, 0, "R5 R6 rx odd divisor rx mask clear");
    run_frame(1'b1, 10,  16'h0000, 16'h0AAA, 12, 0, "R5 R6 rx even divisor rx mask 0xAAA");
    run_frame(1'b0, 6,   16'h0000, 16'h0FFF, 9,  0, "R6 tx ignores rx mask");
    run_frame(1'b0, 8,   16'h0003, 16'h0000, 10, 13, "R7 tx restart mid frame");
    run_frame(1'b1, 8,   16'h0000, 16'h0005, 10, 21, "R7 rx restart mid frame");
    run_frame(1'b0, 2,   16'h0000, 16'h0000, 8,  0, "R8 tx divisor 2 clamps to 4");
    run_frame(1'b1, 1,   16'h0000, 16'h0001, 8,  0, "R8 rx divisor 1 clamps to 4");
    run_frame(1'b0, 416, 16'h0124, 16'h0000, 10, 0, "R2 R4 tx divisor 416");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end
endmodule